// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous single-request host port to a dynamic RAM that has a multiplexed 8-bit address bus and a 16-bit data bus. Each host request carries a 16-bit word address, write data, two byte enables and a write flag. The upper address byte selects the row and the lower byte selects the column. The controller opens a row by pulling RAS low with the row on the address bus. It then performs one column cycle per request: the column goes on the bus and CAS is pulsed. While the row stays open, further requests to the same row are served by CAS pulses alone.

Each minimum delay is a parameter counted in controller clock cycles. One shared phase timer enforces these delays. The controller closes the row in four cases: a request targets another row, no request is waiting, an external refresh agent asks for the memory, or another column cycle would hold RAS low past its maximum. Writes always use early-write timing: WE falls a cycle before CAS, and the controller drives the data bus only while the output enable is high. Byte writes pulse only the CAS strobe of the selected byte lane. Read data is registered at the clock edge where the last access-time condition is met. It is returned with a one-cycle valid pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and after reset, RAS, both CAS strobes, WE and OE are high, the data bus is not driven, rsp_valid_o is low, and req_ready_o is high whenever refresh_req_i is low.
- R2: When RAS falls, dram_addr_o holds req_addr_i[15:8] (row). When either CAS falls, it holds req_addr_i[7:0] (column). A CAS strobe is never low while RAS is high.
- R3: A request to the row that is currently open is accepted without a new RAS falling edge (page mode).
- R4: A request to a different row causes RAS to rise. RAS then stays high for at least T_RP cycles before the next falling edge.
- R5: Write byte enables: req_be_i[0] pulses only the lower CAS and updates data bits 7:0. req_be_i[1] pulses only the upper CAS and updates bits 15:8. With both set, the whole word is written. Reads pulse both strobes.
- R6: In a write, WE is low for at least one cycle before any CAS falls, and the data bus is driven at that CAS fall. OE stays high while WE is low. The data bus is never driven while OE is low.
- R7: Read data is taken at the edge where CAS has been low for at least max(T_CAC, T_AA-1) cycles and RAS for at least T_RAC cycles. It appears on rsp_rdata_o with rsp_valid_o high for exactly one cycle, in request order.
- R8: RAS is never low for more than RAS_MAX_CYC consecutive cycles. A same-row request that would exceed this limit is deferred: the row is closed and then reopened.
- R9: While refresh_req_i is high, no request is accepted and any open row is closed. refresh_ack_o is high only in the idle state, with RAS and both CAS high. The first access after the refresh opens its row with a new RAS fall.
- R10: When no request is pending, the open row is closed and RAS returns high.
- R11: Every RAS low period lasts at least T_RAS_MIN cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address: row in [15:8], column in [7:0] |
| req_be_i | input | 2 | Write byte enables, bit 0 = low byte |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle read-data valid |
| rsp_rdata_o | output | 16 | Read data |
| refresh_req_i | input | 1 | External refresh agent wants the memory |
| refresh_ack_o | output | 1 | Memory idle and precharged |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_casl_no | output | 1 | Lower byte column strobe, active low |
| dram_cash_no | output | 1 | Upper byte column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_addr_o | output | 8 | Multiplexed row/column address |
| dram_dq_o | output | 16 | Data to memory |
| dram_dq_oe_o | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | 16 | Data from memory |

## Verification
The bench builds the controller with T_RP=2, T_RCD=2, T_CAS=1, T_CAC=2, T_AA=3, T_RAC=6, T_CP=1, T_RAS_MIN=4 and RAS_MAX_CYC=20. With T_RAC=6, the first column cycle after a row opens has to stretch CAS to wait for the row access time; later page cycles run at the plain column length. RAS_MAX_CYC=20 allows exactly two column cycles per open row. A burst of same-row requests therefore runs into the open-time limit, and the forced close and reopen show up within a few dozen cycles.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_CAS,
    ST_CPRE,
    ST_OPEN,
    ST_PRE
  } st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_phase_timer.sv
module fpm_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_tracker.sv
module fpm_row_tracker #(
  parameter int ADDR_W = 8,
  parameter int AGE_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              open_i,
  input  logic              close_i,
  input  logic              ras_low_i,
  input  logic [ADDR_W-1:0] row_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [AGE_W-1:0]  age_o
);
  logic [ADDR_W-1:0] row_q;
  logic              open_q;
  logic [AGE_W-1:0]  age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      open_q <= 1'b0;
    end else if (open_i) begin
      row_q  <= row_i;
      open_q <= 1'b1;
    end else if (close_i) begin
      open_q <= 1'b0;
    end
  end

  // cycles RAS has already spent low before the current one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (!ras_low_i)      age_q <= '0;
    else if (age_q != '1)     age_q <= age_q + 1'b1;
  end

  assign hit_o = open_q && (row_i == row_q);
  assign row_o = row_q;
  assign age_o = age_q;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int T_RP        = 1,
  parameter int T_RCD       = 1,
  parameter int T_CAS       = 1,
  parameter int T_CAC       = 1,
  parameter int T_AA        = 1,
  parameter int T_RAC       = 2,
  parameter int T_CP        = 1,
  parameter int T_RAS_MIN   = 2,
  parameter int RAS_MAX_CYC = 500
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_we_i,
  input  logic [2*ADDR_W-1:0]   req_addr_i,
  input  logic [LANES-1:0]      req_be_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [DATA_W-1:0]     rsp_rdata_o,
  input  logic                  refresh_req_i,
  output logic                  refresh_ack_o,
  output logic                  dram_ras_no,
  output logic                  dram_casl_no,
  output logic                  dram_cash_no,
  output logic                  dram_we_no,
  output logic                  dram_oe_no,
  output logic [ADDR_W-1:0]     dram_addr_o,
  output logic [DATA_W-1:0]     dram_dq_o,
  output logic                  dram_dq_oe_o,
  input  logic [DATA_W-1:0]     dram_dq_i
);
  localparam int CAS_CYC    = max2(T_CAS, max2(T_CAC, max2(T_AA - 1, 1)));
  localparam int CAS_LEN    = max2(CAS_CYC, T_RAC);
  localparam int OPEN_LIMIT = max2(RAS_MAX_CYC - (3 + CAS_LEN + T_CP), 0);
  localparam int AGE_W      = $clog2(RAS_MAX_CYC + 2) + 1;
  localparam int TMR_MAX    = max2(max2(T_RCD, CAS_CYC), max2(T_CP, T_RP));
  localparam int TMR_W      = $clog2(TMR_MAX + 1) + 1;

  localparam logic [AGE_W-1:0] OPEN_LIM_A = AGE_W'(OPEN_LIMIT);
  localparam logic [AGE_W-1:0] RAC_M1_A   = AGE_W'(max2(T_RAC - 1, 0));
  localparam logic [AGE_W-1:0] RMIN_M1_A  = AGE_W'(max2(T_RAS_MIN - 1, 0));
  localparam logic [TMR_W-1:0] LD_RCD     = TMR_W'(T_RCD - 1);
  localparam logic [TMR_W-1:0] LD_CAS     = TMR_W'(CAS_CYC - 1);
  localparam logic [TMR_W-1:0] LD_CP      = TMR_W'(T_CP - 1);
  localparam logic [TMR_W-1:0] LD_RP      = TMR_W'(T_RP - 1);

  st_e st_q, st_d;

  logic              tmr_ld, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic              row_open, row_close, row_hit;
  logic [ADDR_W-1:0] row_cur;
  logic [AGE_W-1:0]  ras_age;
  logic              ras_low, rdy, acc, cap;
  logic              rac_ok, min_ok;

  logic              we_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [LANES-1:0]  cas_n;

  fpm_phase_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  fpm_row_tracker #(.ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .open_i    (row_open),
    .close_i   (row_close),
    .ras_low_i (ras_low),
    .row_i     (req_addr_i[2*ADDR_W-1:ADDR_W]),
    .hit_o     (row_hit),
    .row_o     (row_cur),
    .age_o     (ras_age)
  );

  assign rac_ok = (ras_age >= RAC_M1_A);
  assign min_ok = (ras_age >= RMIN_M1_A);

  always_comb begin
    unique case (st_q)
      ST_IDLE: rdy = !refresh_req_i;
      ST_OPEN: rdy = !refresh_req_i && row_hit && (ras_age <= OPEN_LIM_A);
      default: rdy = 1'b0;
    endcase
  end
  assign acc = req_valid_i && rdy;

  always_comb begin
    st_d      = st_q;
    tmr_ld    = 1'b0;
    tmr_val   = '0;
    row_open  = 1'b0;
    row_close = 1'b0;
    cap       = 1'b0;
    unique case (st_q)
      ST_IDLE: if (acc) begin
        row_open = 1'b1;
        tmr_ld   = 1'b1;
        tmr_val  = LD_RCD;
        st_d     = ST_ROW;
      end
      ST_ROW: if (tmr_done) st_d = ST_COL;
      ST_COL: begin
        tmr_ld  = 1'b1;
        tmr_val = LD_CAS;
        st_d    = ST_CAS;
      end
      ST_CAS: if (tmr_done && rac_ok) begin
        cap     = !we_q;
        tmr_ld  = 1'b1;
        tmr_val = LD_CP;
        st_d    = ST_CPRE;
      end
      ST_CPRE: if (tmr_done) st_d = ST_OPEN;
      ST_OPEN: begin
        if (acc) begin
          st_d = ST_COL;
        end else if (min_ok) begin
          // miss, refresh, age limit or idle: precharge
          row_close = 1'b1;
          tmr_ld    = 1'b1;
          tmr_val   = LD_RP;
          st_d      = ST_PRE;
        end
      end
      ST_PRE: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      be_q    <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (acc) begin
      we_q    <= req_we_i;
      be_q    <= req_be_i;
      col_q   <= req_addr_i[ADDR_W-1:0];
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= cap;
      if (cap) rsp_data_q <= dram_dq_i;
    end
  end

  logic col_phase, rw_phase;
  assign ras_low   = (st_q inside {ST_ROW, ST_COL, ST_CAS, ST_CPRE, ST_OPEN});
  assign col_phase = (st_q inside {ST_COL, ST_CAS, ST_CPRE});
  assign rw_phase  = (st_q inside {ST_COL, ST_CAS});

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cas_n[l] = !((st_q == ST_CAS) && (!we_q || be_q[l]));
  end

  assign dram_ras_no   = !ras_low;
  assign dram_casl_no  = cas_n[0];
  assign dram_cash_no  = cas_n[LANES-1];
  assign dram_we_no    = !(we_q && rw_phase);
  assign dram_oe_no    = !(!we_q && rw_phase);
  assign dram_dq_oe_o  = we_q && col_phase;
  assign dram_dq_o     = wdata_q;
  assign dram_addr_o   = col_phase ? col_q : row_cur;

  assign req_ready_o   = rdy;
  assign refresh_ack_o = (st_q == ST_IDLE) && refresh_req_i;
  assign rsp_valid_o   = rsp_valid_q;
  assign rsp_rdata_o   = rsp_data_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RP        = 1,
  parameter int T_RAS_MIN   = 2,
  parameter int RAS_MAX_CYC = 500
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n,
  input logic casl_n,
  input logic cash_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic rsp_valid,
  input logic ack
);
  localparam int CW = $clog2(RAS_MAX_CYC + T_RP + 2) + 1;
  localparam logic [CW-1:0] RP_C   = CW'(T_RP);
  localparam logic [CW-1:0] RMIN_C = CW'(T_RAS_MIN);
  localparam logic [CW-1:0] RMAX_C = CW'(RAS_MAX_CYC);

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= RP_C;
    end else begin
      lo_cnt <= ras_n ? '0 : ((lo_cnt != '1) ? lo_cnt + 1'b1 : lo_cnt);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt != '1) ? hi_cnt + 1'b1 : hi_cnt);
    end
  end

  a_r2_cas_inside_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!casl_n || !cash_n) |-> !ras_n);

  a_r4_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> (hi_cnt >= RP_C));

  a_r6_we_leads_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n && ($fell(casl_n) || $fell(cash_n))) |-> $past(!we_n));

  a_r6_no_contend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n |-> !dq_oe);

  a_r7_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid |=> !rsp_valid);

  a_r8_ras_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n |-> (lo_cnt < RMAX_C));

  a_r9_ack_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> (ras_n && casl_n && cash_n));

  a_r11_ras_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n) |-> (lo_cnt >= RMIN_C));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .T_RP        (T_RP),
  .T_RAS_MIN   (T_RAS_MIN),
  .RAS_MAX_CYC (RAS_MAX_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ras_n     (dram_ras_no),
  .casl_n    (dram_casl_no),
  .cash_n    (dram_cash_no),
  .we_n      (dram_we_no),
  .oe_n      (dram_oe_no),
  .dq_oe     (dram_dq_oe_o),
  .rsp_valid (rsp_valid_o),
  .ack       (refresh_ack_o)
);

// File: tb/fpm_dram_ctrl_test.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_test;
  localparam int P_RP = 2, P_RCD = 2, P_CAS = 1, P_CAC = 2, P_AA = 3;
  localparam int P_RAC = 6, P_CP = 1, P_RMIN = 4, P_RMAX = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, refresh_ack;
  logic [15:0] rsp_rdata;
  logic        ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [7:0]  dram_addr;
  logic [15:0] dq_o, dq_i;

  fpm_dram_ctrl #(
    .T_RP(P_RP), .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CAC(P_CAC), .T_AA(P_AA),
    .T_RAC(P_RAC), .T_CP(P_CP), .T_RAS_MIN(P_RMIN), .RAS_MAX_CYC(P_RMAX)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .refresh_req_i(refresh_req), .refresh_ack_o(refresh_ack),
    .dram_ras_no(ras_n), .dram_casl_no(casl_n), .dram_cash_no(cash_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_addr_o(dram_addr),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model and expectation store
  logic [15:0] mem [int];
  logic [15:0] sb  [int];
  logic [15:0] exp_q [$];
  logic [7:0]  row_m = '0, col_m = '0;
  logic [15:0] rd_word = '0;
  logic        rd_en = 1'b0;
  assign dq_i = rd_en ? rd_word : 16'hDEAD;

  int   ras_falls = 0, ras_lo = 0, ras_hi = 0, cas_lo = 0;
  logic p_ras = 1'b1, p_casl = 1'b1, p_cash = 1'b1, p_we = 1'b1, p_rsp = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      check(!p_rsp, "R7 pulse", {31'd0, p_rsp}, 32'd0);
      check(ras_lo >= P_RAC, "R7 ras access", ras_lo, P_RAC);
      check(cas_lo >= P_CAC && cas_lo + 1 >= P_AA, "R7 cas access", cas_lo, P_CAC);
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_rdata == e, "R7/R2 read data", rsp_rdata, e);
      end
    end
    if (p_ras && !ras_n) begin
      ras_falls++;
      row_m = dram_addr;
      check(ras_hi >= P_RP, "R4 precharge", ras_hi, P_RP);
    end
    if (!p_ras && ras_n) begin
      check(ras_lo >= P_RMIN, "R11 ras min", ras_lo, P_RMIN);
      check(ras_lo <= P_RMAX, "R8 ras max", ras_lo, P_RMAX);
    end
    if ((p_casl && !casl_n) || (p_cash && !cash_n)) begin
      int k;
      logic [15:0] w;
      check(!ras_n, "R2 cas inside ras", {31'd0, ras_n}, 32'd0);
      col_m = dram_addr;
      k = {row_m, col_m};
      if (!we_n) begin
        check(!p_we && dq_oe && oe_n, "R6 early write", {p_we, dq_oe, oe_n}, 3'b011);
        w = mem.exists(k) ? mem[k] : 16'h0;
        if (!casl_n) w[7:0]  = dq_o[7:0];
        if (!cash_n) w[15:8] = dq_o[15:8];
        mem[k] = w;
      end
    end
    rd_en   = !ras_n && !oe_n && (!casl_n || !cash_n);
    rd_word = mem.exists({row_m, col_m}) ? mem[{row_m, col_m}] : 16'h0;
    ras_lo  = ras_n ? 0 : ras_lo + 1;
    ras_hi  = ras_n ? ras_hi + 1 : 0;
    cas_lo  = (casl_n && cash_n) ? 0 : cas_lo + 1;
    p_ras = ras_n; p_casl = casl_n; p_cash = cash_n; p_we = we_n; p_rsp = rsp_valid;
  end

  // called at a falling clock edge, returns at a falling clock edge
  task automatic do_req(input logic we, input logic [1:0] be, input logic [15:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    if (we) begin
      logic [15:0] w;
      w = sb.exists(int'(a)) ? sb[int'(a)] : 16'h0;
      if (be[0]) w[7:0]  = d[7:0];
      if (be[1]) w[15:8] = d[15:8];
      sb[int'(a)] = w;
    end else begin
      exp_q.push_back(sb.exists(int'(a)) ? sb[int'(a)] : 16'h0);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // fields: we, be[1:0], addr[15:0], data[15:0]
  localparam logic [34:0] VEC [0:9] = '{
    {1'b1, 2'b11, 16'h0000, 16'h1111},
    {1'b1, 2'b11, 16'h00FF, 16'h2222},
    {1'b1, 2'b11, 16'hFF00, 16'h3333},
    {1'b0, 2'b11, 16'h0000, 16'h0000},
    {1'b0, 2'b11, 16'h00FF, 16'h0000},
    {1'b1, 2'b01, 16'h00FF, 16'hAAAA},
    {1'b1, 2'b10, 16'h00FF, 16'hBB00},
    {1'b0, 2'b11, 16'h00FF, 16'h0000},
    {1'b0, 2'b11, 16'hFF00, 16'h0000},
    {1'b0, 2'b11, 16'h1234, 16'h0000}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int f0;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 during reset
    check({ras_n, casl_n, cash_n, we_n, oe_n} == 5'h1F, "R1 strobes in reset",
          {ras_n, casl_n, cash_n, we_n, oe_n}, 5'h1F);
    check(!dq_oe && !rsp_valid, "R1 bus idle in reset", {dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && ras_n, "R1 ready after reset", {req_ready, ras_n}, 2'b11);

    // table: R2 addressing, R5 byte lanes, R7 reads
    for (int i = 0; i < 10; i++)
      do_req(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    check(mem[16'h00FF] == 16'hBBAA, "R5 byte lane merge", mem[16'h00FF], 16'hBBAA);

    // R10 idle close
    check(ras_n && !dq_oe, "R10 row closed when idle", {ras_n, dq_oe}, 2'b10);

    // R3 page mode: two same-row requests, one RAS fall
    f0 = ras_falls;
    do_req(1'b1, 2'b11, 16'h0510, 16'h5151);
    do_req(1'b0, 2'b11, 16'h0510, 16'h0);
    repeat (30) @(negedge clk);
    check(ras_falls == f0 + 1, "R3 page hit", ras_falls - f0, 1);

    // R4 row miss: two rows, two RAS falls
    f0 = ras_falls;
    do_req(1'b1, 2'b11, 16'h0601, 16'h6161);
    do_req(1'b1, 2'b11, 16'h0701, 16'h7171);
    repeat (30) @(negedge clk);
    check(ras_falls == f0 + 2, "R4 row miss reopens", ras_falls - f0, 2);

    // R8 open-time limit: four same-row requests need two openings
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) do_req(1'b1, 2'b11, 16'h0800 + 16'(i), 16'h8000 + 16'(i));
    do_req(1'b0, 2'b11, 16'h0802, 16'h0);
    repeat (30) @(negedge clk);
    check(ras_falls == f0 + 3, "R8 limit forces reopen", ras_falls - f0, 3);

    // R5 upper-only write leaves low byte
    do_req(1'b1, 2'b10, 16'h0510, 16'hEE00);
    do_req(1'b0, 2'b11, 16'h0510, 16'h0);
    repeat (30) @(negedge clk);
    check(mem[16'h0510] == 16'hEE51, "R5 upper byte only", mem[16'h0510], 16'hEE51);

    // R9 refresh while idle: request held off
    refresh_req = 1'b1;
    @(negedge clk);
    check(refresh_ack && ras_n, "R9 ack when idle", {refresh_ack, ras_n}, 2'b11);
    f0 = ras_falls;
    req_valid = 1'b1; req_we = 1'b0; req_be = 2'b11; req_addr = 16'h0601;
    repeat (6) @(negedge clk);
    #1;
    check(!req_ready && ras_falls == f0, "R9 no accept under refresh", {req_ready, 8'(ras_falls - f0)}, 0);
    @(negedge clk);
    refresh_req = 1'b0;
    do_req(1'b0, 2'b11, 16'h0601, 16'h0);
    repeat (30) @(negedge clk);
    check(ras_falls == f0 + 1, "R9 access after refresh", ras_falls - f0, 1);

    // R9 refresh with a row open
    do_req(1'b1, 2'b11, 16'h0900, 16'h9999);
    refresh_req = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      seen = refresh_ack;
    end
    check(seen && ras_n, "R9 open row closed for refresh", {seen, ras_n}, 2'b11);
    f0 = ras_falls;
    refresh_req = 1'b0;
    @(negedge clk);
    do_req(1'b0, 2'b11, 16'h0900, 16'h0);
    repeat (30) @(negedge clk);
    check(ras_falls == f0 + 1, "R9 row reopened after refresh", ras_falls - f0, 1);
    check(exp_q.size() == 0, "R7 responses drained", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule